// File: doc/BRIEF.md
# Unsigned 32-by-16 Iterative Divider

This block divides an unsigned 32-bit dividend, presented as two 16-bit halves, by an unsigned 16-bit divisor. It returns a 16-bit quotient and a 16-bit remainder, one quotient bit per clock through a restoring shift-subtract loop.

Before any iteration starts, a guard compares the divisor with the dividend's upper half. A zero divisor, or a divisor no larger than that upper half, means the true quotient cannot fit in 16 bits. In that case the block finishes at once, raises the overflow flag and returns an all-ones quotient. The guard is a full-width magnitude compare, so operands whose top bits are both set are classified like any other.

A caller pulses `start` with the operands while the block is idle. It then waits for the single-cycle `done` pulse. The results and flags hold their values until the next accepted start.

Top module: `udiv_32by16`

## Requirements
- R1: When no overflow is flagged, the outputs satisfy {dvd_hi,dvd_lo} = quo*dvsr + rem with rem < dvsr. The dividend is dvd_hi in bits 31:16 and dvd_lo in bits 15:0.
- R2: When dvsr <= dvd_hi, ovf is 1 at done and quo is FFFF hex. The remainder value is unspecified in that case.
- R3: The overflow decision is exact for operands where bit 15 of both dvd_hi and dvsr is 1. For example, F0F00F0F / F0F0 gives ovf=1, FFFE0000 / FFFF gives ovf=0, and FFFF0000 / FFFF gives ovf=1.
- R4: A zero divisor sets both dz and ovf, and quo is FFFF hex.
- R5: An overflow or divide-by-zero case skips iteration. done rises in the cycle after the clock edge that accepts start.
- R6: A non-overflow division takes 16 iteration cycles. done rises 17 cycles after the accepting edge and stays high for exactly one cycle.
- R7: busy is 1 from the cycle after an accepted start through the done cycle, and 0 once done has ended.
- R8: zero is 1 at done exactly when no overflow is flagged and quo is 0.
- R9: A start raised while busy is 1 is ignored. The running division completes with its original operands.
- R10: After reset, busy, done, ovf, dz and zero are 0, and quo and rem are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a division; accepted only while idle |
| dvd_hi | input | 16 | Dividend bits 31:16 |
| dvd_lo | input | 16 | Dividend bits 15:0 |
| dvsr | input | 16 | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quo | output | 16 | Quotient (FFFF on overflow) |
| rem | output | 16 | Remainder |
| ovf | output | 1 | Quotient does not fit in 16 bits |
| dz | output | 1 | Divisor was zero |
| zero | output | 1 | Quotient is zero |

## Verification
The divider is exercised with small operands, with full-range operands whose quotient lands near FFFF, and with cases that give a zero quotient. These separate the remainder restore path from the subtract path and confirm the zero flag. The overflow guard is probed at its boundary: a divisor one above, equal to, and below the upper dividend half, all with bit 15 set on both sides. This tells an exact magnitude compare apart from one that looks only at the top bits. Zero divisors and starts issued mid-division show the early-exit timing and confirm that the latched operands cannot be overwritten.

// File: rtl/udiv_pkg.sv
// Shared parameters and types for the 32-by-16 divider.
// Assumes the quotient, divisor and each dividend half share one width.
package udiv_pkg;
    localparam int unsigned HALF_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } udiv_state_t;
endpackage

// File: rtl/udiv_guard.sv
// Pre-iteration overflow guard: flags a zero divisor, and a quotient wider
// than W bits (divisor no larger than the upper dividend half).
// Assumes purely combinational use on the operands presented with start.
module udiv_guard #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] dvsr_i,
    output logic         dz_o,
    output logic         ovf_o
);
    // Full-width magnitude compare; no shortcut on the top bits.
    always_comb begin
        dz_o  = (dvsr_i == '0);
        ovf_o = dz_o || (dvsr_i <= hi_i);
    end
endmodule

// File: rtl/udiv_step.sv
// One restoring shift-subtract step: shifts a dividend bit into the partial
// remainder and subtracts the divisor when it fits.
// Assumes rem_i < dvsr_i, so the result also stays below dvsr_i.
module udiv_step #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    input  logic [W-1:0] dvsr_i,
    output logic [W-1:0] rem_o,
    output logic         qbit_o
);
    localparam int unsigned EW = W + 1;

    logic [EW-1:0] trial;
    logic [EW-1:0] diff;

    // Form the shifted trial value and choose between subtract and restore.
    always_comb begin
        trial  = {rem_i, bit_i};
        diff   = trial - {1'b0, dvsr_i};
        qbit_o = (trial >= {1'b0, dvsr_i});
        rem_o  = qbit_o ? diff[W-1:0] : trial[W-1:0];
    end
endmodule

// File: rtl/udiv_ctrl.sv
// Sequencer: accepts start when idle, runs W iteration cycles or finishes at
// once on an early exit, then shows done for one cycle.
// Assumes early_i is valid in the cycle start_i is sampled.
module udiv_ctrl
    import udiv_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic early_i,
    output logic accept_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

    udiv_state_t state_q;
    logic [CW-1:0] cnt_q;

    // Decode the current state into handshake and datapath strobes.
    always_comb begin
        accept_o = start_i && (state_q == ST_IDLE);
        step_o   = (state_q == ST_RUN);
        last_o   = step_o && (cnt_q == LAST_CNT);
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_FIN);
    end

    // Advance the state and the iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept_o) begin
                    state_q <= early_i ? ST_FIN : ST_RUN;
                    cnt_q   <= '0;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_o) state_q <= ST_FIN;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/udiv_32by16.sv
// Unsigned 2W-by-W divider, W = 16 by default. Holds the partial remainder
// and a shift register that trades dividend low bits for quotient bits.
// Assumes operands are stable in the cycle start is sampled.
module udiv_32by16
    import udiv_pkg::*;
#(
    parameter int unsigned W = HALF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvsr,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         ovf,
    output logic         dz,
    output logic         zero
);
    logic         g_dz, g_ovf;
    logic         accept, step, last;
    logic [W-1:0] rem_q, sh_q, dvsr_q;
    logic [W-1:0] nxt_rem;
    logic         nxt_qbit;
    logic         ovf_q, dz_q, zero_q;
    logic [W-1:0] nxt_sh;

    udiv_guard #(.W(W)) u_guard (
        .hi_i   (dvd_hi),
        .dvsr_i (dvsr),
        .dz_o   (g_dz),
        .ovf_o  (g_ovf)
    );

    udiv_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .early_i  (g_ovf),
        .accept_o (accept),
        .step_o   (step),
        .last_o   (last),
        .busy_o   (busy),
        .done_o   (done)
    );

    udiv_step #(.W(W)) u_step (
        .rem_i  (rem_q),
        .bit_i  (sh_q[W-1]),
        .dvsr_i (dvsr_q),
        .rem_o  (nxt_rem),
        .qbit_o (nxt_qbit)
    );

    // Next shift-register value: drop a dividend bit, append a quotient bit.
    always_comb nxt_sh = {sh_q[W-2:0], nxt_qbit};

    // Load operands on accept, iterate while running, settle flags at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            sh_q   <= '0;
            dvsr_q <= '0;
            ovf_q  <= 1'b0;
            dz_q   <= 1'b0;
            zero_q <= 1'b0;
        end else if (accept) begin
            dvsr_q <= dvsr;
            rem_q  <= dvd_hi;
            sh_q   <= g_ovf ? '1 : dvd_lo;
            ovf_q  <= g_ovf;
            dz_q   <= g_dz;
            zero_q <= 1'b0;
        end else if (step) begin
            rem_q <= nxt_rem;
            sh_q  <= nxt_sh;
            if (last) zero_q <= (nxt_sh == '0);
        end
    end

    // Drive the result ports from the held registers.
    always_comb begin
        quo  = sh_q;
        rem  = rem_q;
        ovf  = ovf_q;
        dz   = dz_q;
        zero = zero_q;
    end
endmodule

// File: rtl/udiv_32by16_chk.sv
// Property checker bound to the divider; observes ports only and keeps its
// own copy of the accepted operands and a cycle counter since acceptance.
module udiv_32by16_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dvd_hi,
    input logic [W-1:0] dvd_lo,
    input logic [W-1:0] dvsr,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quo,
    input logic [W-1:0] rem,
    input logic         ovf,
    input logic         dz,
    input logic         zero
);
    localparam int unsigned CW = $clog2(W + 3) + 1;

    logic [W-1:0]  hi_c, lo_c, dv_c;
    logic [CW-1:0] cyc;
    logic [2*W-1:0] recon;

    // Capture accepted operands and count cycles since the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_c <= '0; lo_c <= '0; dv_c <= '0; cyc <= '0;
        end else if (start && !busy) begin
            hi_c <= dvd_hi; lo_c <= dvd_lo; dv_c <= dvsr; cyc <= CW'(1);
        end else if (cyc != '1) begin
            cyc <= cyc + 1'b1;
        end
    end

    always_comb recon = (2*W)'(quo) * (2*W)'(dv_c) + (2*W)'(rem);

    a_r1_quotient_identity: assert property (@(posedge clk) disable iff (!rst_n)
        done && !ovf |-> (recon == {hi_c, lo_c}) && (rem < dv_c));
    a_r2_overflow_forces_ones: assert property (@(posedge clk) disable iff (!rst_n)
        done && ovf |-> quo == '1);
    a_r3_overflow_exact: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ovf == ((dv_c == '0) || (dv_c <= hi_c)));
    a_r4_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> dz == (dv_c == '0));
    a_r5_early_exit_timing: assert property (@(posedge clk) disable iff (!rst_n)
        done && ovf |-> cyc == CW'(1));
    a_r6_iteration_timing: assert property (@(posedge clk) disable iff (!rst_n)
        done && !ovf |-> cyc == CW'(W + 1));
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);
    a_r7_busy_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> zero == (!ovf && quo == '0));
endmodule

bind udiv_32by16 udiv_32by16_chk #(.W(W)) u_chk (.*);

// File: tb/udiv_32by16_test.sv
module udiv_32by16_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
    logic        busy, done, ovf, dz, zero;
    logic [15:0] quo, rem;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    udiv_32by16 uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
        .busy(busy), .done(done), .quo(quo), .rem(rem),
        .ovf(ovf), .dz(dz), .zero(zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one division and verify timing, results and flags against a model.
    task automatic run_div(input string req, input logic [15:0] hi,
                           input logic [15:0] lo, input logic [15:0] dv);
        logic [31:0] dividend;
        logic        exp_ovf;
        logic [15:0] exp_q, exp_r;
        int          n;
        dividend = {hi, lo};
        exp_ovf  = (dv == 16'h0) || (dv <= hi);
        exp_q    = exp_ovf ? 16'hFFFF : 16'(dividend / {16'h0, dv});
        exp_r    = exp_ovf ? 16'h0 : 16'(dividend % {16'h0, dv});
        @(negedge clk);
        dvd_hi = hi; dvd_lo = lo; dvsr = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        check({req, "/R7"}, "busy after start", 32'(busy), 32'd1);
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check({req, (exp_ovf ? "/R5" : "/R6")}, "done latency", n, exp_ovf ? 1 : 17);
        check({req, "/R2"}, "ovf", 32'(ovf), 32'(exp_ovf));
        check({req, "/R4"}, "dz", 32'(dz), 32'(dv == 16'h0));
        check({req, "/R1"}, "quotient", 32'(quo), 32'(exp_q));
        if (!exp_ovf) check({req, "/R1"}, "remainder", 32'(rem), 32'(exp_r));
        check({req, "/R8"}, "zero", 32'(zero), 32'(!exp_ovf && exp_q == 16'h0));
        @(negedge clk);
        check({req, "/R6"}, "done single cycle", 32'(done), 32'd0);
        check({req, "/R7"}, "busy cleared", 32'(busy), 32'd0);
    endtask

    // R10: outputs after reset.
    task automatic test_reset();
        check("R10", "busy", 32'(busy), 0);
        check("R10", "done", 32'(done), 0);
        check("R10", "flags", {29'd0, ovf, dz, zero}, 0);
        check("R10", "quo/rem", {quo, rem}, 0);
    endtask

    // R9: a second start during a run must not disturb it.
    task automatic test_start_while_busy();
        int n;
        @(negedge clk);
        dvd_hi = 16'h0012; dvd_lo = 16'h3456; dvsr = 16'h0100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        dvd_hi = 16'hFFFF; dvd_lo = 16'hFFFF; dvsr = 16'h0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 4;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check("R9", "done latency unchanged", n, 17);
        check("R9", "quotient of first operands", 32'(quo), 32'h1234);
        check("R9", "remainder of first operands", 32'(rem), 32'h0056);
        check("R9", "no dz from ignored start", 32'(dz), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_div("R1 small", 16'h0000, 16'd1000, 16'd7);
        run_div("R1 large", 16'h7FFF, 16'hFFFF, 16'hFFFF);
        run_div("R1 near-max quotient", 16'hFFFE, 16'hFFFF, 16'hFFFF);
        run_div("R8 zero quotient", 16'h0000, 16'h0005, 16'h000A);
        run_div("R2 hi above divisor", 16'h0040, 16'h0000, 16'h0020);
        run_div("R3 example", 16'hF0F0, 16'h0F0F, 16'hF0F0);
        run_div("R3 equal", 16'hFFFF, 16'h0000, 16'hFFFF);
        run_div("R3 one below", 16'hFFFE, 16'h0000, 16'hFFFF);
        run_div("R3 hi over", 16'h8001, 16'h1234, 16'h8000);
        run_div("R3 hi under", 16'h8000, 16'hFFFF, 16'h8001);
        run_div("R4 zero divisor", 16'h1234, 16'h5678, 16'h0000);
        run_div("R4 all zero", 16'h0000, 16'h0000, 16'h0000);
        test_start_while_busy();
        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule